// File: doc/BRIEF.md
# Bus-to-SRAM Block Transfer Engine

This engine moves a block of bytes between a byte-wide instrument-bus port and a local byte-addressed SRAM buffer. It works in either direction. A host sets it up through a small register file. The host loads a block counter with the negated byte count, picks the direction and sets the enable bit. The engine then moves one byte per accepted handshake. Each byte goes to or from the next SRAM offset, and the counter steps up by one until it wraps to zero.

The engine stops when the counter reaches zero (terminal count). In the receive direction it also stops when a byte arrives flagged as the end of a message (buffer end). When it stops, it parks in a halted state. The host restarts it by writing a one to the stream register. Each event can latch into a write-one-to-clear status bit. Latched events, together with an external protocol-controller interrupt, can be routed to a single host interrupt line.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset, all readable registers return 0, the engine is idle and not halted, and `bus_rx_ready`, `bus_tx_valid` and `host_irq` are 0.
- R2: Writes to offset 0 and offset 1 load counter bits [7:0] and [14:8]. Reads of the same offsets return them, with offset 1 bit 7 always 0. Offset 2 keeps only its low 4 bits and does not affect the counter. The remaining count is `(-(lo | mid<<8)) & 0x7FFF`.
- R3: With control register (offset 3) = 0x60 (bit 6 enable, bit 5 bus-to-host), each accepted `bus_rx_valid & bus_rx_ready` byte is written to SRAM at offsets 0, 1, 2, … in order, and the counter rises by one per byte.
- R4: With control = 0x40, `bus_tx_valid` presents SRAM data from offsets 0, 1, 2, … in order and advances on each cycle where `bus_tx_ready` is 1.
- R5: When the counter reaches zero the engine halts. Event status (offset 5) bit 5 sets if event enable (offset 6) bit 5 is 1.
- R6: A received byte with `bus_rx_eom` is stored, then the engine halts. Event status bit 4 sets if event enable bit 4 is 1.
- R7: Event status bits 5 and 4 clear only when a 1 is written to that bit position. Writing 0 there leaves them unchanged. A new event in the same cycle as the clear wins.
- R8: When its event enable bit is 0, an event does not latch a status bit, but the engine still halts.
- R9: Event status bit 0 shows `proto_irq`. Bit 1 is the request: (tc & irq-enable bit 5) | (be & irq-enable bit 4) | (`proto_irq` & irq-enable bit 0), where irq-enable is offset 7. `host_irq` is that request gated by mode register (offset 8) bit 5.
- R10: Stream register (offset 4) bit 0 reads 1 while halted, and no byte moves while halted. Writing 1 to bit 0 resumes the engine with the SRAM offset back at 0. Writing 0 there has no effect.
- R11: Clearing control bit 6 stops movement at once and clears the halted state. The counter keeps its value for readback.
- R12: A counter loaded with 0 moves a full block of 0x8000 bytes before terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_rx_valid | input | 1 | Received byte present |
| bus_rx_data | input | 8 | Received byte |
| bus_rx_eom | input | 1 | Received byte ends a message |
| bus_rx_ready | output | 1 | Engine accepts a received byte |
| bus_tx_valid | output | 1 | Byte to send is present |
| bus_tx_data | output | 8 | Byte to send |
| bus_tx_ready | input | 1 | Bus takes the byte |
| sram_addr | output | 15 | SRAM byte offset |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write enable |
| sram_rdata | input | 8 | SRAM read data for `sram_addr` (same cycle) |
| proto_irq | input | 1 | Protocol controller interrupt |
| host_irq | output | 1 | Interrupt to host |

## Verification
Receive blocks use random lengths and random gaps in `bus_rx_valid`. This separates the handshake from the byte count, and an SRAM marker one slot past the block shows whether the engine stopped exactly on time. Other receive runs place the end-of-message flag at a random position, sometimes on the last byte. These show whether the buffer-end and terminal-count paths work on their own or together. Send blocks use a randomly throttled `bus_tx_ready` to check ordering under backpressure, plus one full 0x8000-byte block for the zero-load case. Directed steps cover write-one-to-clear, event gating, interrupt routing, restart and abort.

// File: rtl/blk_xfer_engine.sv
`timescale 1ns/1ps
module blk_xfer_engine #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             bus_rx_valid,
  input  logic [7:0]       bus_rx_data,
  input  logic             bus_rx_eom,
  output logic             bus_rx_ready,
  output logic             bus_tx_valid,
  output logic [7:0]       bus_tx_data,
  input  logic             bus_tx_ready,
  output logic [CNT_W-1:0] sram_addr,
  output logic [7:0]       sram_wdata,
  output logic             sram_we,
  input  logic [7:0]       sram_rdata,
  input  logic             proto_irq,
  output logic             host_irq
);
  localparam int MID_W = CNT_W - 8;
  localparam logic [3:0] A_CLO = 4'd0, A_CMID = 4'd1, A_CHI = 4'd2, A_CTRL = 4'd3,
                         A_STRM = 4'd4, A_EVST = 4'd5, A_EVEN = 4'd6, A_IRQE = 4'd7,
                         A_MODE = 4'd8;

  logic [CNT_W-1:0] cnt, ptr;
  logic [3:0] cnt_hi;
  logic [7:0] ctrl_q, even_q, irqe_q, mode_q;
  logic halted, st_tc, st_be;

  wire active  = ctrl_q[6] & ~halted;
  wire to_host = ctrl_q[5];
  assign bus_rx_ready = active & to_host;
  assign bus_tx_valid = active & ~to_host;
  assign bus_tx_data  = sram_rdata;
  assign sram_addr    = ptr;
  assign sram_wdata   = bus_rx_data;
  assign sram_we      = bus_rx_ready & bus_rx_valid;

  wire fire   = sram_we | (bus_tx_valid & bus_tx_ready);
  wire last   = fire & (&cnt);
  wire be_hit = sram_we & bus_rx_eom;
  wire clr_w  = reg_wr && reg_addr == A_EVST;
  wire irq_req = (st_tc & irqe_q[5]) | (st_be & irqe_q[4]) | (proto_irq & irqe_q[0]);
  assign host_irq = irq_req & mode_q[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ptr <= '0; cnt_hi <= '0; halted <= 1'b0;
      ctrl_q <= '0; even_q <= '0; irqe_q <= '0; mode_q <= '0;
      st_tc <= 1'b0; st_be <= 1'b0;
    end else begin
      if (fire) begin
        cnt <= cnt + 1'b1;
        ptr <= ptr + 1'b1;
      end
      if (last | be_hit) halted <= 1'b1;
      if (!ctrl_q[6]) begin
        ptr <= '0;
        halted <= 1'b0;
      end
      if (reg_wr && reg_addr == A_STRM && reg_wdata[0] && halted) begin
        halted <= 1'b0;
        ptr <= '0;
      end
      if (reg_wr) begin
        case (reg_addr)
          A_CLO:  cnt[7:0] <= reg_wdata;
          A_CMID: cnt[CNT_W-1:8] <= MID_W'(reg_wdata);
          A_CHI:  cnt_hi <= reg_wdata[3:0];
          A_CTRL: ctrl_q <= reg_wdata & 8'h60;
          A_EVEN: even_q <= reg_wdata & 8'h30;
          A_IRQE: irqe_q <= reg_wdata & 8'h31;
          A_MODE: mode_q <= reg_wdata & 8'h20;
          default: ;
        endcase
      end
      st_tc <= (st_tc & ~(clr_w & reg_wdata[5])) | (last & even_q[5]);
      st_be <= (st_be & ~(clr_w & reg_wdata[4])) | (be_hit & even_q[4]);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CLO:  reg_rdata = cnt[7:0];
      A_CMID: reg_rdata = 8'(cnt[CNT_W-1:8]);
      A_CHI:  reg_rdata = {4'b0, cnt_hi};
      A_CTRL: reg_rdata = ctrl_q;
      A_STRM: reg_rdata = {7'b0, halted};
      A_EVST: reg_rdata = {2'b0, st_tc, st_be, 2'b0, irq_req, proto_irq};
      A_EVEN: reg_rdata = even_q;
      A_IRQE: reg_rdata = irqe_q;
      A_MODE: reg_rdata = mode_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !reg_wr) |=> cnt == $past(cnt) + 1'b1);
  assert_tc_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (&cnt) && !reg_wr) |=> (halted && cnt == '0));
  assert_eom_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && bus_rx_eom && !reg_wr) |=> halted);
  assert_w1c_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_tc) |-> $past(reg_wr && reg_addr == A_EVST && reg_wdata[5]));
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (st_tc || st_be || proto_irq));
  assert_halt_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!bus_rx_ready && !bus_tx_valid && !sram_we));
  assert_abort_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && !reg_wdata[6]) |=> (!bus_rx_ready && !bus_tx_valid));
endmodule

// File: tb/blk_xfer_engine_test.sv
`timescale 1ns/1ps
module blk_xfer_engine_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [3:0] reg_addr = 0; logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_rx_valid = 0, bus_rx_eom = 0, bus_rx_ready; logic [7:0] bus_rx_data = 0;
  logic bus_tx_valid, bus_tx_ready = 0; logic [7:0] bus_tx_data;
  logic [14:0] sram_addr; logic [7:0] sram_wdata, sram_rdata; logic sram_we;
  logic proto_irq = 0, host_irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] expd [0:63];

  always #4 clk = ~clk;

  blk_xfer_engine uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .bus_rx_valid, .bus_rx_data, .bus_rx_eom, .bus_rx_ready, .bus_tx_valid, .bus_tx_data,
    .bus_tx_ready, .sram_addr, .sram_wdata, .sram_we, .sram_rdata, .proto_irq, .host_irq);

  assign sram_rdata = mem[sram_addr[11:0]];
  always @(posedge clk) if (sram_we) mem[sram_addr[11:0]] <= sram_wdata;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output int d);
    @(negedge clk); reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  task automatic remaining(output int r);
    int lo, mid;
    rd(4'd0, lo); rd(4'd1, mid);
    r = (-(lo | (mid << 8))) & 32'h7FFF;
  endtask

  task automatic prep(int n, logic [7:0] ctrl);
    int neg = (-n) & 32'h7FFF;
    wr(4'd3, 8'h00); wr(4'd5, 8'h30);
    wr(4'd0, neg[7:0]); wr(4'd1, neg[15:8]); wr(4'd3, ctrl);
  endtask

  task automatic run_rx(int n, int eom_at, int pct, output int stored);
    int k = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'hA5 ^ i[7:0];
    prep(n, 8'h60);
    for (int g = 0; g < 2000; g++) begin
      bit v; logic [7:0] d;
      @(negedge clk);
      v = ($urandom % 100) < pct; d = 8'($urandom);
      bus_rx_valid = v; bus_rx_data = d; bus_rx_eom = v && (k == eom_at);
      #1;
      if (!bus_rx_ready) break;
      if (v) begin expd[k] = d; k++; end
    end
    bus_rx_valid = 0; bus_rx_eom = 0;
    stored = k;
  endtask

  task automatic run_tx(int n, int pct, output int sent, output int bad);
    int idx = 0; bad = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    prep(n, 8'h40);
    for (int g = 0; g < 70000; g++) begin
      bit r;
      @(negedge clk);
      r = ($urandom % 100) < pct; bus_tx_ready = r;
      #1;
      if (!bus_tx_valid) break;
      if (r) begin
        if (bus_tx_data !== mem[idx % 4096]) bad++;
        idx++;
      end
    end
    bus_tx_ready = 0;
    sent = idx;
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk); bus_rx_valid = 1; bus_rx_data = d; bus_rx_eom = 0;
    @(negedge clk); bus_rx_valid = 0;
  endtask

  function automatic int rx_errs(int stored);
    int e = 0;
    for (int i = 0; i < stored; i++) if (mem[i] !== expd[i]) e++;
    return e;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v, n, e, s, bad, r;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R1 reg reset", v, 0); end
    chk("R1 idle outputs", {bus_rx_ready, bus_tx_valid, host_irq}, 0);

    wr(4'd0, 8'h34); wr(4'd1, 8'hFF);
    rd(4'd1, v); chk("R2 mid masked", v, 8'h7F);
    rd(4'd0, v); chk("R2 low byte", v, 8'h34);
    wr(4'd2, 8'hFF); rd(4'd2, v); chk("R2 high nibble", v, 8'h0F);
    rd(4'd1, v); chk("R2 high no effect", v, 8'h7F);

    wr(4'd6, 8'h30);
    for (int t = 0; t < 6; t++) begin
      n = 1 + $urandom % 40;
      run_rx(n, -1, 60, s);
      chk("R3 rx stored count", s, n);
      chk("R3 rx data order", rx_errs(s), 0);
      chk("R3 stop on time", mem[s], 8'hA5 ^ 8'(s));
      remaining(r); chk("R3 counter end", r, 0);
      rd(4'd5, v); chk("R5 tc status", v, 8'h20);
      rd(4'd4, v); chk("R10 halted after tc", v, 1);
    end

    for (int t = 0; t < 5; t++) begin
      n = 5 + $urandom % 30; e = (t == 0) ? n - 1 : $urandom % n;
      run_rx(n, e, 70, s);
      chk("R6 stored through eom", s, e + 1);
      chk("R6 data", rx_errs(s), 0);
      chk("R6 nothing past eom", mem[s], 8'hA5 ^ 8'(s));
      remaining(r); chk("R6 remaining", r, n - s);
      rd(4'd5, v); chk("R6 be status", v, (e == n - 1) ? 8'h30 : 8'h10);
    end

    for (int t = 0; t < 5; t++) begin
      n = 1 + $urandom % 50;
      run_tx(n, 50, s, bad);
      chk("R4 tx count", s, n);
      chk("R4 tx data order", bad, 0);
      rd(4'd5, v); chk("R5 tx tc status", v, 8'h20);
    end

    run_tx(32768, 100, s, bad);
    chk("R12 full block count", s, 32768);
    chk("R12 full block data", bad, 0);
    remaining(r); chk("R12 counter back to zero", r, 0);

    wr(4'd5, 8'h10); rd(4'd5, v); chk("R7 write zero keeps tc", v, 8'h20);
    wr(4'd5, 8'h20); rd(4'd5, v); chk("R7 write one clears tc", v, 8'h00);

    wr(4'd6, 8'h00);
    run_rx(8, 3, 100, s);
    chk("R8 stops on eom ungated", s, 4);
    rd(4'd5, v); chk("R8 be not latched", v, 8'h00);
    rd(4'd4, v); chk("R8 halted anyway", v, 1);
    run_tx(3, 100, s, bad);
    rd(4'd5, v); chk("R8 tc not latched", v, 8'h00);

    wr(4'd6, 8'h30);
    run_tx(2, 100, s, bad);
    wr(4'd7, 8'h20); rd(4'd5, v); chk("R9 request bit", v, 8'h22);
    chk("R9 mode gate off", host_irq, 0);
    wr(4'd8, 8'h20); #1; chk("R9 mode gate on", host_irq, 1);
    wr(4'd7, 8'h10); #1; chk("R9 be route only", host_irq, 0);
    wr(4'd7, 8'h01); proto_irq = 1;
    rd(4'd5, v); chk("R9 proto pass", v, 8'h23);
    chk("R9 proto irq", host_irq, 1);
    proto_irq = 0; #1; chk("R9 proto drop", host_irq, 0);
    wr(4'd7, 8'h00); wr(4'd8, 8'h00);

    run_rx(10, 2, 100, s);
    chk("R10 stored before halt", s, 3);
    wr(4'd4, 8'h00); rd(4'd4, v); chk("R10 write zero no restart", v, 1);
    wr(4'd4, 8'h01); rd(4'd4, v); chk("R10 restart clears halt", v, 0);
    push(8'h5A);
    chk("R10 restart offset zero", mem[0], 8'h5A);
    remaining(r); chk("R10 count resumes", r, 6);

    prep(10, 8'h60);
    push(8'h11); push(8'h22); push(8'h33);
    wr(4'd3, 8'h20); #1;
    chk("R11 abort stops rx", bus_rx_ready, 0);
    remaining(r); chk("R11 counter held", r, 7);
    rd(4'd4, v); chk("R11 not halted", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule